// File: doc/BRIEF.md
# Interrupt-Started DMA Engine with Add-and-Store

This block is a small DMA engine started by peripheral interrupt requests rather than by dedicated request lines. A request counts only when it is raised at the top priority level and the engine is switched on in its control register. The engine then fetches the parameter descriptor bound to that request source. It carries out one of four operations: a memory copy, a store of an immediate constant, or a store of the sum of two operands. In the sum, the first operand comes from memory or from the immediate field, and the second always comes from memory.

Each descriptor holds a unit count, three addresses, an immediate value and a configuration byte. The configuration byte selects the operation, an 8- or 16-bit unit, independent fixed or forward stepping for source and destination, single or burst mode, and chaining. The memory port is byte-wide and synchronous, with read data one cycle after the request. A 16-bit unit is therefore moved as two byte accesses, and the port carries a 17-bit byte address so that a unit starting at 0xFFFF reaches 0x10000. When a descriptor's count reaches zero, the engine pulses a completion interrupt. If chaining is on, it also moves that source on to a follow-up descriptor.

Top module: `irq_dma_engine`

## Requirements
- R1: A request pulse on `irq_req[s]` is accepted only when `irq_lvl` for that source equals 7, control bit 5 is 1 and control bit 3 is 0. A request arriving under any other condition leads to no memory access.
- R2: The descriptor configuration `desc_cfg` encodes: bits[1:0] operation (0 copy, 1 immediate, 2 add memory+memory, 3 add immediate+memory), bit2 16-bit unit, bit3 source forward, bit4 destination forward, bit5 burst, bit6 chain. A copy writes the bytes read at the source address to the destination address.
- R3: An immediate operation writes the descriptor's immediate value to the destination without reading memory.
- R4: An add operation writes the first operand (source memory, or the immediate value) plus the second operand (memory at the second-operand address), truncated to the unit width with the carry dropped.
- R5: A 16-bit unit is moved as two byte accesses, low byte at the lower address. An 8-bit unit uses exactly one write.
- R6: A forward address advances by 1 (8-bit) or 2 (16-bit) after each unit. A fixed address stays put. Source (with the second-operand address) and destination choose independently.
- R7: In single mode, each accepted request moves exactly one unit. The decremented count and stepped addresses are kept for the next request.
- R8: In burst mode, one accepted request moves units until the count reaches zero.
- R9: `done_irq` is a one-cycle pulse, with `done_src` naming the source, raised only when a descriptor's count reaches zero.
- R10: With chain set, reaching zero switches that source to the descriptor slot named by its `desc_next` field for the following request.
- R11: A 16-bit unit at address 0xFFFF uses byte addresses 0x0FFFF and 0x10000 for both reads and writes. No other address above 0xFFFF is ever issued.
- R12: When several sources are pending, the lowest source index is served first. Each accepted request is served once.
- R13: A request whose descriptor count is zero causes no memory access and no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control value; bit 5 enable, bit 3 must be 0 |
| desc_we | input | 1 | Descriptor slot write strobe |
| desc_idx | input | IW | Descriptor slot to write |
| desc_count | input | 16 | Unit count |
| desc_src | input | 16 | Source / first operand address |
| desc_op2 | input | 16 | Second operand address |
| desc_dst | input | 16 | Destination address |
| desc_imm | input | 16 | Immediate value |
| desc_cfg | input | 7 | Configuration byte (see R2) |
| desc_next | input | IW | Follow-up slot for chaining |
| irq_req | input | NSRC | Request pulses, one per source |
| irq_lvl | input | 3*NSRC | Priority level per source |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 17 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after a read request |
| done_irq | output | 1 | Completion pulse |
| done_src | output | SW | Source that completed |

## Verification
A request pulse sampled at edge E becomes pending at E, is dispatched at E+1, and its descriptor is loaded at E+2. An immediate 8-bit write then appears on the port in the cycle after E+2. Each read byte costs two cycles, each write byte one, and the step cycle adds one more, so `done_irq` is visible after the step edge. The longest unit, a 16-bit add, finishes within about 14 cycles. The bench records every write and every completion pulse at the clock edge in which they occur. It compares those logs only after a fixed window of 60 to 80 cycles, far beyond every latency, so the checks do not depend on the exact dispatch cycle.

// File: rtl/irqdma_pkg.sv
package irqdma_pkg;

    localparam int LVL_W     = 3;
    localparam int LVL_TOP   = 7;
    localparam int CTRL_EN   = 5;
    localparam int CTRL_FAST = 3;

    typedef enum logic [1:0] {
        OP_COPY   = 2'd0,
        OP_IMM    = 2'd1,
        OP_ADD_MM = 2'd2,
        OP_ADD_IM = 2'd3
    } op_e;

    // MSB first: chain is bit 6, op is bits 1:0
    typedef struct packed {
        logic chain;
        logic burst;
        logic dst_fwd;
        logic src_fwd;
        logic wide;
        op_e  op;
    } cfg_t;

    typedef struct packed {
        logic [15:0] count;
        logic [15:0] src;
        logic [15:0] op2;
        logic [15:0] dst;
        logic [15:0] imm;
        cfg_t        cfg;
    } desc_t;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_RDA, S_CAPA, S_RDB, S_CAPB, S_WR, S_STEP
    } st_e;

    function automatic logic op_reads_a(op_e op);
        return (op == OP_COPY) || (op == OP_ADD_MM);
    endfunction

    function automatic logic op_is_add(op_e op);
        return op[1];
    endfunction

    function automatic logic [15:0] addr_step(logic wide, logic fwd);
        return fwd ? (wide ? 16'd2 : 16'd1) : 16'd0;
    endfunction

    function automatic st_e first_phase(op_e op);
        if (op_reads_a(op))       return S_RDA;
        else if (op == OP_ADD_IM) return S_RDB;
        else                      return S_WR;
    endfunction

endpackage

// File: rtl/irqdma_arb.sv
module irqdma_arb
    import irqdma_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int SW   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [NSRC-1:0]        irq_req,
    input  logic [NSRC*LVL_W-1:0]  irq_lvl,
    input  logic                   take,
    output logic                   any,
    output logic [NSRC-1:0]        pend,
    output logic [NSRC-1:0]        grant,
    output logic [SW-1:0]          grant_idx
);
    logic [NSRC-1:0] qual;
    logic [NSRC-1:0] pend_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_qual
        assign qual[g] = en && irq_req[g] &&
                         (irq_lvl[g*LVL_W +: LVL_W] == LVL_W'(LVL_TOP));
    end

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = SW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~(take ? grant : '0)) | qual;
    end

    assign any  = |pend_q;
    assign pend = pend_q;
endmodule

// File: rtl/irqdma_desc.sv
module irqdma_desc
    import irqdma_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int NDESC = 8,
    parameter int IW    = 3,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  desc_t         wr_desc,
    input  logic [IW-1:0] wr_next,
    input  logic [SW-1:0] sel,
    input  logic          wb_en,
    input  desc_t         wb_desc,
    input  logic          adv_en,
    output desc_t         rd_desc
);
    desc_t         slot_q [NDESC];
    logic [IW-1:0] next_q [NDESC];
    logic [IW-1:0] ptr_q  [NSRC];

    assign rd_desc = slot_q[ptr_q[sel]];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NDESC; i++) begin
                slot_q[i] <= '0;
                next_q[i] <= '0;
            end
            for (int s = 0; s < NSRC; s++) ptr_q[s] <= IW'(s);
        end else begin
            if (wr_en) begin
                slot_q[wr_idx] <= wr_desc;
                next_q[wr_idx] <= wr_next;
            end
            if (wb_en)  slot_q[ptr_q[sel]] <= wb_desc;
            if (adv_en) ptr_q[sel] <= next_q[ptr_q[sel]];
        end
    end
endmodule

// File: rtl/irqdma_seq.sv
module irqdma_seq
    import irqdma_pkg::*;
#(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [SW-1:0] start_src,
    input  desc_t         rd_desc,
    output logic          idle,
    output logic [SW-1:0] cur_src,
    output logic          mem_req,
    output logic          mem_we,
    output logic [16:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          wb_en,
    output desc_t         wb_desc,
    output logic          adv_en,
    output logic          done_irq,
    output logic [SW-1:0] done_src
);
    st_e           st;
    desc_t         w;
    logic          hi_q;
    logic [SW-1:0] src_q;
    logic [15:0]   opa, opb, res, cnt_n;
    logic          last;

    assign last    = !w.cfg.wide || hi_q;
    assign res     = op_is_add(w.cfg.op) ? opa + opb : opa;
    assign cnt_n   = w.count - 16'd1;
    assign idle    = (st == S_IDLE);
    assign cur_src = src_q;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            S_RDA: begin
                mem_req  = 1'b1;
                mem_addr = {1'b0, w.src} + {16'd0, hi_q};
            end
            S_RDB: begin
                mem_req  = 1'b1;
                mem_addr = {1'b0, w.op2} + {16'd0, hi_q};
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {1'b0, w.dst} + {16'd0, hi_q};
                mem_wdata = hi_q ? res[15:8] : res[7:0];
            end
            default: ;
        endcase
    end

    always_comb begin
        wb_desc       = w;
        wb_desc.count = cnt_n;
        wb_desc.src   = w.src + addr_step(w.cfg.wide, w.cfg.src_fwd);
        wb_desc.op2   = w.op2 + addr_step(w.cfg.wide, w.cfg.src_fwd);
        wb_desc.dst   = w.dst + addr_step(w.cfg.wide, w.cfg.dst_fwd);
    end

    assign wb_en  = (st == S_STEP);
    assign adv_en = wb_en && (cnt_n == 16'd0) && w.cfg.chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            w        <= '0;
            hi_q     <= 1'b0;
            src_q    <= '0;
            opa      <= '0;
            opb      <= '0;
            done_irq <= 1'b0;
            done_src <= '0;
        end else begin
            done_irq <= 1'b0;
            unique case (st)
                S_IDLE: if (start) begin
                    src_q <= start_src;
                    st    <= S_LOAD;
                end
                S_LOAD: begin
                    w    <= rd_desc;
                    hi_q <= 1'b0;
                    if (!op_reads_a(rd_desc.cfg.op)) opa <= rd_desc.imm;
                    st <= (rd_desc.count == 16'd0) ? S_IDLE : first_phase(rd_desc.cfg.op);
                end
                S_RDA: st <= S_CAPA;
                S_CAPA: begin
                    if (hi_q) opa[15:8] <= mem_rdata;
                    else      opa[7:0]  <= mem_rdata;
                    hi_q <= !last;
                    if (last) st <= op_is_add(w.cfg.op) ? S_RDB : S_WR;
                    else      st <= S_RDA;
                end
                S_RDB: st <= S_CAPB;
                S_CAPB: begin
                    if (hi_q) opb[15:8] <= mem_rdata;
                    else      opb[7:0]  <= mem_rdata;
                    hi_q <= !last;
                    st   <= last ? S_WR : S_RDB;
                end
                S_WR: begin
                    hi_q <= !last;
                    if (last) st <= S_STEP;
                end
                S_STEP: begin
                    w <= wb_desc;
                    if (cnt_n == 16'd0) begin
                        done_irq <= 1'b1;
                        done_src <= src_q;
                    end
                    st <= (cnt_n != 16'd0 && w.cfg.burst) ? first_phase(w.cfg.op) : S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_dma_engine.sv
module irq_dma_engine
    import irqdma_pkg::*;
#(
    parameter  int NSRC  = 4,
    parameter  int NDESC = 8,
    localparam int IW    = $clog2(NDESC),
    localparam int SW    = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_we,
    input  logic [7:0]            ctrl_wdata,
    input  logic                  desc_we,
    input  logic [IW-1:0]         desc_idx,
    input  logic [15:0]           desc_count,
    input  logic [15:0]           desc_src,
    input  logic [15:0]           desc_op2,
    input  logic [15:0]           desc_dst,
    input  logic [15:0]           desc_imm,
    input  logic [6:0]            desc_cfg,
    input  logic [IW-1:0]         desc_next,
    input  logic [NSRC-1:0]       irq_req,
    input  logic [NSRC*LVL_W-1:0] irq_lvl,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [16:0]           mem_addr,
    output logic [7:0]            mem_wdata,
    input  logic [7:0]            mem_rdata,
    output logic                  done_irq,
    output logic [SW-1:0]         done_src
);
    logic            en_q, fast_q, dma_en;
    logic            any_w, idle_w, take_w, wb_en_w, adv_en_w;
    logic [NSRC-1:0] pend_w, grant_w;
    logic [SW-1:0]   grant_idx_w, cur_src_w;
    desc_t           wr_desc_w, rd_desc_w, wb_desc_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            fast_q <= 1'b0;
        end else if (ctrl_we) begin
            en_q   <= ctrl_wdata[CTRL_EN];
            fast_q <= ctrl_wdata[CTRL_FAST];
        end
    end

    assign dma_en = en_q && !fast_q;
    assign take_w = idle_w && any_w && dma_en;

    always_comb begin
        wr_desc_w.count = desc_count;
        wr_desc_w.src   = desc_src;
        wr_desc_w.op2   = desc_op2;
        wr_desc_w.dst   = desc_dst;
        wr_desc_w.imm   = desc_imm;
        wr_desc_w.cfg   = cfg_t'(desc_cfg);
    end

    irqdma_arb #(.NSRC(NSRC), .SW(SW)) arb_i (
        .clk(clk), .rst(rst), .en(dma_en), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .take(take_w), .any(any_w), .pend(pend_w), .grant(grant_w),
        .grant_idx(grant_idx_w)
    );

    irqdma_desc #(.NSRC(NSRC), .NDESC(NDESC), .IW(IW), .SW(SW)) desc_i (
        .clk(clk), .rst(rst), .wr_en(desc_we), .wr_idx(desc_idx),
        .wr_desc(wr_desc_w), .wr_next(desc_next), .sel(cur_src_w),
        .wb_en(wb_en_w), .wb_desc(wb_desc_w), .adv_en(adv_en_w),
        .rd_desc(rd_desc_w)
    );

    irqdma_seq #(.SW(SW)) seq_i (
        .clk(clk), .rst(rst), .start(take_w), .start_src(grant_idx_w),
        .rd_desc(rd_desc_w), .idle(idle_w), .cur_src(cur_src_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wb_en(wb_en_w), .wb_desc(wb_desc_w), .adv_en(adv_en_w),
        .done_irq(done_irq), .done_src(done_src)
    );
endmodule

// File: rtl/irqdma_chk.sv
module irqdma_chk #(
    parameter int NSRC = 4,
    parameter int LVLW = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NSRC-1:0]      irq_req,
    input logic [NSRC*LVLW-1:0] irq_lvl,
    input logic                 en_q,
    input logic                 fast_q,
    input logic [NSRC-1:0]      pend,
    input logic [NSRC-1:0]      grant,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic [16:0]          mem_addr,
    input logic                 done_irq
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // R1
        qualify_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pend[g]) |-> $past(irq_req[g] && (irq_lvl[g*LVLW +: LVLW] == 3'd7)
                                     && en_q && !fast_q));
    end

    // R12
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5
    write_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R11
    addr_span_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_addr[16]) |-> (mem_addr[15:0] == 16'd0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);
endmodule

bind irq_dma_engine irqdma_chk #(.NSRC(NSRC), .LVLW(3)) chk_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .en_q(en_q), .fast_q(fast_q), .pend(pend_w), .grant(grant_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .done_irq(done_irq)
);

// File: tb/irq_dma_engine_tb_top.sv
module irq_dma_engine_tb_top;
    localparam int NSRC = 4;
    localparam int NDESC = 8;
    localparam int IW = 3;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    logic            ctrl_we;
    logic [7:0]      ctrl_wdata;
    logic            desc_we;
    logic [IW-1:0]   desc_idx, desc_next;
    logic [15:0]     desc_count, desc_src, desc_op2, desc_dst, desc_imm;
    logic [6:0]      desc_cfg;
    logic [NSRC-1:0] irq_req;
    logic [11:0]     irq_lvl;
    logic            mem_req, mem_we, done_irq;
    logic [16:0]     mem_addr;
    logic [7:0]      mem_wdata, mem_rdata;
    logic [SW-1:0]   done_src;

    irq_dma_engine #(.NSRC(NSRC), .NDESC(NDESC)) dut_i (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .desc_we(desc_we), .desc_idx(desc_idx), .desc_count(desc_count),
        .desc_src(desc_src), .desc_op2(desc_op2), .desc_dst(desc_dst),
        .desc_imm(desc_imm), .desc_cfg(desc_cfg), .desc_next(desc_next),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done_irq(done_irq), .done_src(done_src)
    );

    // memory content is a computed function of the byte address
    function automatic logic [7:0] rmodel(input logic [16:0] a);
        logic [7:0] r;
        r = a[7:0] ^ 8'h3C;
        r = r + {a[14:8], 1'b0};
        if (a[16]) r = r + 8'h40;
        return r;
    endfunction

    always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= rmodel(mem_addr);

    logic        clr;
    logic [16:0] wa [64];
    logic [7:0]  wd [64];
    logic [1:0]  ds [8];
    int          nw, nd;
    always @(posedge clk) begin
        if (clr) begin
            nw <= 0;
            nd <= 0;
        end else if (!rst) begin
            if (mem_req && mem_we && nw < 64) begin
                wa[nw] <= mem_addr;
                wd[nw] <= mem_wdata;
                nw <= nw + 1;
            end
            if (done_irq && nd < 8) begin
                ds[nd] <= done_src;
                nd <= nd + 1;
            end
        end
    end

    int nchk = 0;
    int nerr = 0;
    bit fin = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v; tick(1); ctrl_we = 1'b0;
    endtask

    task automatic put_desc(input int idx, input logic [15:0] cnt, src, op2, dst, imm,
                            input logic [6:0] cfg, input int nxt);
        desc_we = 1'b1; desc_idx = IW'(idx); desc_count = cnt; desc_src = src;
        desc_op2 = op2; desc_dst = dst; desc_imm = imm; desc_cfg = cfg;
        desc_next = IW'(nxt);
        tick(1);
        desc_we = 1'b0;
    endtask

    task automatic fire(input logic [NSRC-1:0] which);
        irq_req = which; tick(1); irq_req = '0;
    endtask

    task automatic clear_logs();
        clr = 1'b1; tick(1); clr = 1'b0;
    endtask

    typedef struct packed {
        logic [6:0]  cfg;
        logic [15:0] src;
        logic [15:0] op2;
        logic [15:0] dst;
        logic [15:0] imm;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{7'h00, 16'h0120, 16'h0000, 16'h0300, 16'h0000},
        '{7'h04, 16'h1234, 16'h0000, 16'h0400, 16'h0000},
        '{7'h01, 16'h0000, 16'h0000, 16'h0500, 16'hBEEF},
        '{7'h05, 16'h0000, 16'h0000, 16'h0502, 16'hCAFE},
        '{7'h06, 16'h00F0, 16'h2222, 16'h0600, 16'h0000},
        '{7'h03, 16'h0000, 16'h0010, 16'h0610, 16'h00F0},
        '{7'h02, 16'h0377, 16'h0188, 16'h0620, 16'h0000}
    };

    initial begin
        rst = 1'b1; clr = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; desc_we = 1'b0;
        desc_idx = '0; desc_next = '0; desc_count = '0; desc_src = '0; desc_op2 = '0;
        desc_dst = '0; desc_imm = '0; desc_cfg = '0; irq_req = '0; irq_lvl = {4{3'd7}};
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R9 reset mem_req", mem_req, 0);
        chk("R9 reset done_irq", done_irq, 0);
        clear_logs();

        // R1: qualification
        put_desc(0, 16'd1, 16'h0000, 16'h0000, 16'h0100, 16'h005A, 7'h01, 0);
        set_ctrl(8'h28);
        fire(4'b0001); tick(40);
        chk("R1 fast bit set blocks", nw, 0);
        set_ctrl(8'h20);
        irq_lvl[2:0] = 3'd6;
        fire(4'b0001); tick(40);
        chk("R1 level 6 blocks", nw, 0);
        irq_lvl[2:0] = 3'd7;
        set_ctrl(8'h00);
        fire(4'b0001); tick(40);
        chk("R1 enable clear blocks", nw, 0);
        set_ctrl(8'h20);
        fire(4'b0001); tick(40);
        chk("R1 accepted write count", nw, 1);
        chk("R1 accepted data", wd[0], 8'h5A);

        // table of single-unit operations on source 0
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic [15:0] a, b, r;
            logic [1:0] op;
            int n;
            string tg;
            t = VEC[v];
            op = t.cfg[1:0];
            n = t.cfg[2] ? 2 : 1;
            tg = (op == 2'd0) ? "R2 copy" : (op == 2'd1) ? "R3 immediate" : "R4 add";
            a = (op == 2'd0 || op == 2'd2) ?
                {rmodel({1'b0, t.src} + 17'd1), rmodel({1'b0, t.src})} : t.imm;
            b = {rmodel({1'b0, t.op2} + 17'd1), rmodel({1'b0, t.op2})};
            r = op[1] ? a + b : a;
            put_desc(0, 16'd1, t.src, t.op2, t.dst, t.imm, t.cfg, 0);
            clear_logs();
            fire(4'b0001); tick(60);
            chk("R5 write count", nw, n);
            chk(tg, {wa[0], wd[0]}, {1'b0, t.dst, r[7:0]});
            if (n == 2) chk(tg, {wa[1], wd[1]}, {{1'b0, t.dst} + 17'd1, r[15:8]});
            chk("R9 one done", nd, 1);
            chk("R9 done source", ds[0], 0);
        end

        // R6 / R7: single mode, forward 16-bit copy, count 3
        put_desc(0, 16'd3, 16'h0100, 16'h0000, 16'h0700, 16'h0000, 7'h1C, 0);
        clear_logs();
        fire(4'b0001); tick(60);
        chk("R7 one unit per request", nw, 2);
        chk("R9 no done before zero", nd, 0);
        fire(4'b0001); tick(60);
        fire(4'b0001); tick(60);
        chk("R7 three units total", nw, 6);
        for (int k = 0; k < 6; k++) begin
            chk("R6 forward addr", wa[k], 17'h0700 + 17'(k));
            chk("R6 forward data", wd[k], rmodel(17'h0100 + 17'(k)));
        end
        chk("R9 done at zero", nd, 1);
        fire(4'b0001); tick(60);
        chk("R13 zero count no write", nw, 6);
        chk("R13 zero count no done", nd, 1);

        // R8 / R6: burst, 8-bit, forward source, fixed destination, source 1
        put_desc(1, 16'd3, 16'h0200, 16'h0000, 16'h0800, 16'h0000, 7'h28, 1);
        clear_logs();
        fire(4'b0010); tick(80);
        chk("R8 burst units", nw, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R6 fixed dst", wa[k], 17'h0800);
            chk("R8 burst data", wd[k], rmodel(17'h0200 + 17'(k)));
        end
        chk("R9 burst one done", nd, 1);
        chk("R9 burst done source", ds[0], 1);

        // R10: chain from slot 2 to slot 5 on source 2
        put_desc(2, 16'd1, 16'h0000, 16'h0000, 16'h0900, 16'h0011, 7'h41, 5);
        put_desc(5, 16'd1, 16'h0000, 16'h0000, 16'h0910, 16'h0022, 7'h01, 5);
        clear_logs();
        fire(4'b0100); tick(60);
        fire(4'b0100); tick(60);
        chk("R10 two writes", nw, 2);
        chk("R10 first slot", {wa[0], wd[0]}, {17'h0900, 8'h11});
        chk("R10 chained slot", {wa[1], wd[1]}, {17'h0910, 8'h22});
        chk("R10 done per slot", nd, 2);

        // R11: 16-bit unit at 0xFFFF, source 3
        put_desc(3, 16'd1, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 7'h04, 3);
        clear_logs();
        fire(4'b1000); tick(60);
        chk("R11 low byte", {wa[0], wd[0]}, {17'h0FFFF, rmodel(17'h0FFFF)});
        chk("R11 high byte", {wa[1], wd[1]}, {17'h10000, rmodel(17'h10000)});

        // R12: sources 1 and 3 requested together
        put_desc(1, 16'd1, 16'h0000, 16'h0000, 16'h0A00, 16'h0033, 7'h01, 1);
        put_desc(3, 16'd1, 16'h0000, 16'h0000, 16'h0A10, 16'h0044, 7'h01, 3);
        clear_logs();
        fire(4'b1010); tick(80);
        chk("R12 served once each", nw, 2);
        chk("R12 lower index first", wa[0], 17'h0A00);
        chk("R12 higher index second", wa[1], 17'h0A10);
        chk("R12 done order", {ds[0], ds[1]}, {2'd1, 2'd3});

        fin = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule